// File: doc/BRIEF.md
# Aging Memory Request Scheduler

This block sits in front of a set of per-bank command sequencers and keeps a small pool of outstanding memory requests. Each request carries a direction (read or write), a bank and a row. On every cycle the scheduler looks at the whole pool and offers one request downstream. The policy is layered. Requests that have waited too long come first. Next are requests in the current bus direction whose row is already open in their bank. Then any request in the current direction. When nothing matches, the request that has waited longest is offered.

The scheduler follows the direction of the last granted request, so reads and writes come out in runs. It also watches how many writes are queued. When the write backlog grows large, it enters a drain phase that forces the direction to write. The phase stays in force until the backlog is small again. DRAM timing and data movement are left to the sequencers.

Requests enter through a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` depends only on the fill level of the pool. Grants leave through a valid/ready port. `gnt_valid` is high whenever the pool is not empty. The offered entry is chosen again on every cycle, so the payload may change while `gnt_ready` is low. The grant takes effect on an edge where both signals are high, and that pair is the one-cycle grant strobe.

Top module: `mem_req_sched`

## Requirements
- R1: A request is stored when `req_valid` and `req_ready` are both high at a clock edge. It goes into the lowest-numbered free slot with age 0. `req_ready` is low exactly when all 8 slots hold requests.
- R2: `gnt_valid` is high exactly when at least one slot holds a request. When `gnt_valid` and `gnt_ready` are both high at an edge, the slot given by `gnt_idx` is freed at that edge. The offered request is reported on `gnt_idx`, `gnt_write`, `gnt_bank` and `gnt_row`.
- R3: A queued request whose age is at least 32 is offered before every other request. When more than one request has reached that age, the lowest slot index wins.
- R4: When R3 does not apply, a request in the current direction is preferred if it hits. A hit means its bank has `open_valid` set for that bank and the bank's `open_rows` field equals the request's row. Bank b's field is at bits [14*b+13:14*b]. Among several hits, the lowest slot index wins.
- R5: When R3 and R4 do not apply, the lowest-indexed request in the current direction is offered.
- R6: When none of R3 to R5 applies, the request with the largest age is offered. Ties go to the lowest slot index.
- R7: The age of each queued request rises by one on every edge at which it is not granted. The age saturates at 63.
- R8: Drain mode is shown on `drain_active`. It becomes 1 at the edge after the queued write count is 6 or more. It becomes 0 at the edge after the count is 2 or fewer. Between those levels it holds its value. While drain mode is active, the current direction is write.
- R9: Outside drain mode, the current direction is the direction of the most recently granted request (1 = write). After reset the current direction is read.
- R10: After reset the pool is empty: `gnt_valid` is 0, `req_ready` is 1 and `drain_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Pool can take a request |
| req_write | input | 1 | New request direction, 1 = write |
| req_bank | input | 2 | New request bank |
| req_row | input | 14 | New request row |
| open_valid | input | 4 | Per-bank flag: a row is open |
| open_rows | input | 56 | Open row per bank, 14 bits each, bank 0 in the low bits |
| gnt_valid | output | 1 | A request is offered |
| gnt_ready | input | 1 | Sequencers take the offered request |
| gnt_idx | output | 3 | Slot index of the offered request |
| gnt_write | output | 1 | Direction of the offered request |
| gnt_bank | output | 2 | Bank of the offered request |
| gnt_row | output | 14 | Row of the offered request |
| drain_active | output | 1 | Write drain mode in force |

## Verification
Two rules can apply to the same pick: the starvation escape and write drain. An old read can reach the age limit while drain mode is forcing writes. The bench provokes this by holding `gnt_ready` low while the pool is filled with a mostly-write mix. Every queued request then ages past the limit while the write count sits at or above the drain level. The reference model requires the aged entry to win over the drain direction. A checker property allows a non-write grant in drain mode only when an aged entry exists. Enqueue and grant in the same cycle are also exercised, with the pool near full.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int BANK_W    = 2;
  localparam int ROW_W     = 14;
  localparam int AGE_W     = 6;
  localparam int NUM_BANKS = 1 << BANK_W;

  typedef struct packed {
    logic              valid;
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [AGE_W-1:0]  age;
  } slot_t;
endpackage

// File: rtl/mrs_queue.sv
module mrs_queue
  import mrs_pkg::*;
#(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enq,
  input  logic                  enq_wr,
  input  logic [BANK_W-1:0]     enq_bank,
  input  logic [ROW_W-1:0]      enq_row,
  input  logic                  deq,
  input  logic [IDX_W-1:0]      deq_idx,
  output slot_t [N-1:0]         slots,
  output logic                  full,
  output logic [N-1:0]          wr_vec
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [IDX_W-1:0] free_idx;
  logic [N-1:0]     busy;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &busy;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign busy[g]   = slots[g].valid;
    assign wr_vec[g] = slots[g].valid & slots[g].wr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (enq && free_idx == IDX_W'(g)) begin
        slots[g].valid <= 1'b1;
        slots[g].wr    <= enq_wr;
        slots[g].bank  <= enq_bank;
        slots[g].row   <= enq_row;
        slots[g].age   <= '0;
      end else if (deq && deq_idx == IDX_W'(g)) begin
        slots[g].valid <= 1'b0;
      end else if (slots[g].valid && slots[g].age != AGE_MAX) begin
        slots[g].age <= slots[g].age + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrs_picker.sv
module mrs_picker
  import mrs_pkg::*;
#(
  parameter int N         = 8,
  parameter int AGE_LIMIT = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  slot_t [N-1:0]                  slots,
  input  logic  [NUM_BANKS-1:0]          open_vld,
  input  logic  [NUM_BANKS-1:0][ROW_W-1:0] open_row,
  input  logic                           cur_wr,
  output logic                           any,
  output logic                           aged_any,
  output logic [IDX_W-1:0]               pick_idx
);
  logic [N-1:0] aged, hit, same, vld;

  for (genvar g = 0; g < N; g++) begin : g_flag
    assign vld[g]  = slots[g].valid;
    assign aged[g] = slots[g].valid && (slots[g].age >= AGE_W'(AGE_LIMIT));
    assign same[g] = slots[g].valid && (slots[g].wr == cur_wr);
    assign hit[g]  = same[g] && open_vld[slots[g].bank]
                     && (open_row[slots[g].bank] == slots[g].row);
  end

  function automatic logic [IDX_W-1:0] lowest(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] old_idx;
  logic [AGE_W-1:0] old_age;
  logic             old_seen;

  always_comb begin
    old_idx  = '0;
    old_age  = '0;
    old_seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!old_seen || slots[i].age > old_age)) begin
        old_idx  = IDX_W'(i);
        old_age  = slots[i].age;
        old_seen = 1'b1;
      end
    end
  end

  assign any      = |vld;
  assign aged_any = |aged;

  always_comb begin
    if (|aged)      pick_idx = lowest(aged);
    else if (|hit)  pick_idx = lowest(hit);
    else if (|same) pick_idx = lowest(same);
    else            pick_idx = old_idx;
  end
endmodule

// File: rtl/mrs_dir_ctrl.sv
module mrs_dir_ctrl #(
  parameter int N        = 8,
  parameter int DRAIN_HI = 6,
  parameter int DRAIN_LO = 2,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr_vec,
  input  logic         fire,
  input  logic         fire_wr,
  output logic         drain_q,
  output logic         cur_wr
);
  logic [CNT_W-1:0] wcnt;
  logic             dir_q;

  always_comb begin
    wcnt = '0;
    for (int i = 0; i < N; i++) wcnt = wcnt + CNT_W'(wr_vec[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      drain_q <= (wcnt >= CNT_W'(DRAIN_HI)) || (drain_q && wcnt > CNT_W'(DRAIN_LO));
      if (fire) dir_q <= fire_wr;
    end
  end

  assign cur_wr = drain_q | dir_q;
endmodule

// File: rtl/mem_req_sched.sv
module mem_req_sched
  import mrs_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int AGE_LIMIT   = 32,
  parameter int DRAIN_HI    = 6,
  parameter int DRAIN_LO    = 2,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic [ROW_W-1:0]           req_row,
  input  logic [NUM_BANKS-1:0]       open_valid,
  input  logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       gnt_valid,
  input  logic                       gnt_ready,
  output logic [IDX_W-1:0]           gnt_idx,
  output logic                       gnt_write,
  output logic [BANK_W-1:0]          gnt_bank,
  output logic [ROW_W-1:0]           gnt_row,
  output logic                       drain_active
);
  slot_t [NUM_ENTRIES-1:0]         slots;
  logic  [NUM_ENTRIES-1:0]         wr_vec;
  logic  [NUM_BANKS-1:0][ROW_W-1:0] orow;
  logic                            full, any, aged_any, cur_wr, fire, enq;
  logic  [IDX_W-1:0]               pick_idx;

  assign orow = open_rows;

  assign req_ready = !full;
  assign enq       = req_valid && !full;
  assign fire      = any && gnt_ready;

  mrs_queue #(.N(NUM_ENTRIES)) u_queue (
    .clk(clk), .rst_n(rst_n), .enq(enq), .enq_wr(req_write),
    .enq_bank(req_bank), .enq_row(req_row), .deq(fire), .deq_idx(pick_idx),
    .slots(slots), .full(full), .wr_vec(wr_vec)
  );

  mrs_picker #(.N(NUM_ENTRIES), .AGE_LIMIT(AGE_LIMIT)) u_picker (
    .slots(slots), .open_vld(open_valid), .open_row(orow), .cur_wr(cur_wr),
    .any(any), .aged_any(aged_any), .pick_idx(pick_idx)
  );

  mrs_dir_ctrl #(.N(NUM_ENTRIES), .DRAIN_HI(DRAIN_HI), .DRAIN_LO(DRAIN_LO)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_vec(wr_vec), .fire(fire),
    .fire_wr(slots[pick_idx].wr), .drain_q(drain_active), .cur_wr(cur_wr)
  );

  assign gnt_valid = any;
  assign gnt_idx   = pick_idx;
  assign gnt_write = slots[pick_idx].wr;
  assign gnt_bank  = slots[pick_idx].bank;
  assign gnt_row   = slots[pick_idx].row;
endmodule

// File: rtl/mrs_sched_chk.sv
module mrs_sched_chk #(
  parameter int N        = 8,
  parameter int DRAIN_HI = 6,
  parameter int DRAIN_LO = 2,
  localparam int CNT_W = $clog2(N + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic gnt_valid,
  input logic gnt_ready,
  input logic gnt_write,
  input logic drain_active,
  input logic aged_any
);
  logic [CNT_W-1:0] occ, wocc;
  logic             in_fire, out_fire;

  assign in_fire  = req_valid && req_ready;
  assign out_fire = gnt_valid && gnt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ  <= '0;
      wocc <= '0;
    end else begin
      occ  <= occ + CNT_W'(in_fire) - CNT_W'(out_fire);
      wocc <= wocc + CNT_W'(in_fire && req_write) - CNT_W'(out_fire && gnt_write);
    end
  end

  p_ready_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (occ != CNT_W'(N)));
  p_grant_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ != '0) |-> gnt_valid);
  p_grant_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !gnt_valid);
  p_drain_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wocc >= CNT_W'(DRAIN_HI)) |=> drain_active);
  p_drain_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wocc <= CNT_W'(DRAIN_LO)) |=> !drain_active);
  p_drain_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_active && gnt_valid && !aged_any) |-> gnt_write);
endmodule

bind mem_req_sched mrs_sched_chk #(
  .N(NUM_ENTRIES), .DRAIN_HI(DRAIN_HI), .DRAIN_LO(DRAIN_LO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .gnt_valid(gnt_valid), .gnt_ready(gnt_ready),
  .gnt_write(gnt_write), .drain_active(drain_active), .aged_any(aged_any)
);

// File: tb/mem_req_sched_tb_top.sv
`timescale 1ns/1ps
module mem_req_sched_tb_top;
  localparam int N = 8;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, gnt_ready = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [13:0] req_row = '0;
  logic [3:0]  open_valid = '0;
  logic [55:0] open_rows = '0;
  logic        req_ready, gnt_valid, gnt_write, drain_active;
  logic [2:0]  gnt_idx;
  logic [1:0]  gnt_bank;
  logic [13:0] gnt_row;

  always #2 clk = ~clk;

  mem_req_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
    .open_valid(open_valid), .open_rows(open_rows), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_idx(gnt_idx), .gnt_write(gnt_write),
    .gnt_bank(gnt_bank), .gnt_row(gnt_row), .drain_active(drain_active)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_v[N]; bit m_w[N]; int m_b[N]; int m_r[N]; int m_a[N];
  bit m_dir = 0, m_drain = 0;
  int tier_seen[4];
  int drain_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_cycle();
    int wcnt = 0, cnt = 0, pick = -1, tier = 0, free = -1, best = -1;
    bit cur, full, fire, enq;
    string tag;
    for (int i = 0; i < N; i++) begin
      if (m_v[i]) cnt++;
      if (m_v[i] && m_w[i]) wcnt++;
    end
    cur = m_drain ? 1'b1 : m_dir;
    for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_a[i] >= 32) begin pick = i; tier = 0; end
    if (pick < 0)
      for (int i = N - 1; i >= 0; i--)
        if (m_v[i] && m_w[i] == cur && open_valid[m_b[i]] &&
            open_rows[m_b[i]*14 +: 14] == 14'(m_r[i])) begin pick = i; tier = 1; end
    if (pick < 0)
      for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_w[i] == cur) begin pick = i; tier = 2; end
    if (pick < 0)
      for (int i = 0; i < N; i++)
        if (m_v[i] && (best < 0 || m_a[i] > best)) begin pick = i; best = m_a[i]; tier = 3; end
    full = (cnt == N);
    chk(req_ready == !full, "R1 req_ready", int'(req_ready), int'(!full));
    chk(gnt_valid == (cnt != 0), "R2 gnt_valid", int'(gnt_valid), int'(cnt != 0));
    chk(drain_active == m_drain, "R8 drain_active", int'(drain_active), int'(m_drain));
    if (cnt != 0) begin
      case (tier)
        0: tag = "R3 aged pick";
        1: tag = "R4 row-hit pick";
        2: tag = "R5/R9 same-direction pick";
        default: tag = "R6/R7 oldest pick";
      endcase
      tier_seen[tier]++;
      chk(int'(gnt_idx) == pick, tag, int'(gnt_idx), pick);
      chk(gnt_write == m_w[pick] && int'(gnt_bank) == m_b[pick] && int'(gnt_row) == m_r[pick],
          "R2 grant payload", int'(gnt_row), m_r[pick]);
    end
    if (m_drain) drain_seen++;
    fire = (cnt != 0) && gnt_ready;
    enq  = req_valid && !full;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free = i;
    for (int i = 0; i < N; i++)
      if (m_v[i] && !(fire && i == pick) && m_a[i] < 63) m_a[i]++;
    if (fire) begin m_v[pick] = 0; m_dir = m_w[pick]; end
    if (enq) begin
      m_v[free] = 1; m_w[free] = req_write; m_b[free] = int'(req_bank);
      m_r[free] = int'(req_row); m_a[free] = 0;
    end
    m_drain = (wcnt >= 6) || (m_drain && wcnt > 2);
  endtask

  task automatic step(input bit rv, input bit rw, input bit gr);
    @(negedge clk);
    req_valid = rv; req_write = rw; gnt_ready = gr;
    req_bank = 2'($urandom_range(0, 3));
    req_row  = 14'($urandom_range(0, 3));
    if ($urandom_range(0, 7) == 0) begin
      open_valid = 4'($urandom);
      for (int b = 0; b < NB; b++) open_rows[b*14 +: 14] = 14'($urandom_range(0, 3));
    end
    #1;
    model_cycle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; m_b[i] = 0; m_r[i] = 0; m_a[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk(gnt_valid == 1'b0, "R10 gnt_valid after reset", int'(gnt_valid), 0);
    chk(req_ready == 1'b1, "R10 req_ready after reset", int'(req_ready), 1);
    chk(drain_active == 1'b0, "R10 drain after reset", int'(drain_active), 0);
    // R1: fill with grants stalled, then push against full pool
    for (int k = 0; k < 12; k++) step(1'b1, k[0], 1'b0);
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 1'b1);
    // R8: write flood then release; R3: hold stalled until entries age out
    for (int k = 0; k < 10; k++) step(1'b1, (k % 5) != 0, 1'b0);
    for (int k = 0; k < 40; k++) step(1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) step(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 12; k++) step(1'b0, 1'b0, 1'b1);
    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      int ph = (k / 500) % 4;
      bit wr = (ph == 1) ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 1) == 1);
      bit gr = (ph == 2) ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 2) != 0);
      step($urandom_range(0, 3) != 0, wr, gr);
    end
    chk(tier_seen[0] > 0, "R3 aged pick exercised", tier_seen[0], 1);
    chk(tier_seen[1] > 0, "R4 row-hit pick exercised", tier_seen[1], 1);
    chk(tier_seen[2] > 0, "R5 same-direction pick exercised", tier_seen[2], 1);
    chk(tier_seen[3] > 0, "R6 oldest pick exercised", tier_seen[3], 1);
    chk(drain_seen > 0, "R8 drain mode exercised", drain_seen, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule